// File: doc/BRIEF.md
# CAN Fault Confinement Counter Unit

This unit keeps the transmit and receive error counters of a CAN node and derives its fault confinement state (error-active, error-passive, bus-off). A protocol engine feeds it one-cycle event strobes: transmit and receive errors, successful transmissions and receptions, a stuff error seen during arbitration while sending, errors found inside an error or overload flag, excess dominant bits after a flag, and the detection of 11 consecutive recessive bits on an idle bus. The unit reports the counters, the state, an error-warning status bit with a change interrupt, a one-cycle pulse when bus-off recovery ends, and whether the node must insert a suspend-transmission field.

The node enters bus-off when a transmit-side increment would push the TEC past its maximum. TEC is then loaded with the number of idle detections still required (128) and counts down once per idle detection. The warning status and REC stay frozen throughout that recovery. A software reset-mode input freezes every counter and status bit. The protocol exception rules are applied exactly: a stuff error during arbitration cancels the transmit increment of that cycle only, and later errors inside flags still add to TEC.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, tec_o and rec_o are 0, state_o is 0 (error-active), and err_warn_o, err_warn_irq_o and recov_done_o are 0.
- R2: Outside reset mode and bus-off, a pulse on tx_err_i, flag_bit_err_i or dom_after_flag_i adds 8 to TEC. A pulse on tx_ok_i with none of those subtracts 1 from TEC, and TEC never goes below 0. The change is visible on tec_o in the cycle after the strobe.
- R3: Outside reset mode and bus-off, rx_err_i adds 1 to REC, saturating at 255. Otherwise rx_ok_i subtracts 1 from REC, never going below 0.
- R4: When arb_stuff_err_i is high in the same cycle as tx_err_i, the TEC increment from tx_err_i is suppressed. flag_bit_err_i and dom_after_flag_i still add 8 regardless.
- R5: state_o is coded 0 for error-active, 1 for error-passive and 2 for bus-off. It reads 1 whenever TEC or REC is 128 or more outside bus-off. A +8 applied to a TEC between 120 and 127 shows state 1 in the very next cycle.
- R6: A TEC increment applied while TEC is above 247 enters bus-off (state 2) and loads TEC with 128.
- R7: In bus-off, only bus_idle_i changes TEC, lowering it by 1. The idle detection that takes TEC from 1 to 0 clears both counters, returns state to 0, and raises recov_done_o for exactly one cycle.
- R8: err_warn_o goes to 1 when TEC or REC is at or above warn_limit_i, one cycle after the counter change. err_warn_irq_o pulses for one cycle whenever err_warn_o changes.
- R9: During bus-off, err_warn_o holds its value and err_warn_irq_o stays 0.
- R10: While reset_mode_i is 1, all event strobes, including bus_idle_i, leave TEC, REC, state and err_warn_o unchanged.
- R11: During bus-off, rx_err_i and rx_ok_i leave REC unchanged.
- R12: suspend_tx_o is 1 only when state_o is 1 and transmitter_i is 1. A node that lost arbitration (transmitter_i 0) gets 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_mode_i | input | 1 | Software reset mode, freezes the unit |
| warn_limit_i | input | 8 | Error-warning threshold (96 typical) |
| tx_err_i | input | 1 | Transmitter error strobe |
| rx_err_i | input | 1 | Receiver error strobe |
| tx_ok_i | input | 1 | Successful transmission strobe |
| rx_ok_i | input | 1 | Successful reception strobe |
| arb_stuff_err_i | input | 1 | Stuff error during arbitration while transmitting |
| flag_bit_err_i | input | 1 | Bit error inside an active error or overload flag |
| dom_after_flag_i | input | 1 | Too many dominant bits after a flag |
| bus_idle_i | input | 1 | 11 consecutive recessive bits detected |
| transmitter_i | input | 1 | Node was transmitter of the last message |
| tec_o | output | 8 | Transmit error counter / idles remaining in bus-off |
| rec_o | output | 8 | Receive error counter |
| state_o | output | 2 | Confinement state code |
| err_warn_o | output | 1 | Error-warning status |
| err_warn_irq_o | output | 1 | One-cycle pulse on warning status change |
| recov_done_o | output | 1 | One-cycle pulse at bus-off recovery completion |
| suspend_tx_o | output | 1 | Suspend-transmission field required |

## Verification
The hardest situation to reach from the ports is the end of a full bus-off recovery with a non-zero REC and a warning status that is already set. The stimulus first drives TEC up through the 120 to 127 window into error-passive and adds receive errors. It then continues to 255 and one step further into bus-off. It walks all 128 idle detections, sampling the interrupt after each one, with a reset-mode pause part way through. It finally checks that the counters clear together, the completion pulse lasts one cycle, and the warning status drops with its interrupt only after bus-off has ended.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/can_fc_tec.sv
module can_fc_tec #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned TX_INC      = 8,
  parameter int unsigned RECOV_IDLES = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze_i,
  input  logic             tx_err_i,
  input  logic             arb_stuff_i,
  input  logic             flag_err_i,
  input  logic             dom_err_i,
  input  logic             tx_ok_i,
  input  logic             idle_i,
  output logic [CNT_W-1:0] tec_o,
  output logic             bus_off_o,
  output logic             recov_fire_o,
  output logic             recov_done_o
);
  localparam int unsigned      CNT_MAX  = (1 << CNT_W) - 1;
  localparam logic [CNT_W-1:0] INC_LIM  = CNT_W'(CNT_MAX - TX_INC);
  localparam logic [CNT_W-1:0] INC_V    = CNT_W'(TX_INC);
  localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_IDLES);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] tec_q, tec_d;
  logic             boff_q, boff_d;
  logic             done_q;
  logic             inc;
  logic             upd;

  // stuff error in arbitration cancels only the plain transmit increment
  assign inc = (tx_err_i & ~arb_stuff_i) | flag_err_i | dom_err_i;
  assign upd = ~freeze_i;

  always_comb begin
    tec_d        = tec_q;
    boff_d       = boff_q;
    recov_fire_o = 1'b0;
    if (!freeze_i) begin
      if (boff_q) begin
        if (idle_i) begin
          if (tec_q == ONE) begin
            tec_d        = '0;
            boff_d       = 1'b0;
            recov_fire_o = 1'b1;
          end else begin
            tec_d = tec_q - ONE;
          end
        end
      end else if (inc) begin
        if (tec_q > INC_LIM) begin
          boff_d = 1'b1;
          tec_d  = RECOV_LD;
        end else begin
          tec_d = tec_q + INC_V;
        end
      end else if (tx_ok_i && tec_q != '0) begin
        tec_d = tec_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q  <= '0;
      boff_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= recov_fire_o;
      if (upd) begin
        tec_q  <= tec_d;
        boff_q <= boff_d;
      end
    end
  end

  assign tec_o        = tec_q;
  assign bus_off_o    = boff_q;
  assign recov_done_o = done_q;

  AST_TEC_HOLD_RSTMODE: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |=> $stable(tec_q)); // R10
  AST_BOFF_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (boff_q && !idle_i) |=> $stable(tec_q)); // R7
  AST_BOFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze_i && !boff_q && inc && tec_q > INC_LIM) |=> (boff_q && tec_q == RECOV_LD)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    recov_done_o |=> !recov_done_o); // R7
endmodule

// File: rtl/can_fc_rec.sv
module can_fc_rec #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze_i,
  input  logic             clr_i,
  input  logic             rx_err_i,
  input  logic             rx_ok_i,
  output logic [CNT_W-1:0] rec_o
);
  localparam logic [CNT_W-1:0] REC_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] rec_q, rec_d;
  logic             upd;

  assign upd = clr_i | ~freeze_i;

  always_comb begin
    rec_d = rec_q;
    if (clr_i) begin
      rec_d = '0;
    end else if (rx_err_i) begin
      if (rec_q != REC_MAX) rec_d = rec_q + ONE;
    end else if (rx_ok_i && rec_q != '0) begin
      rec_d = rec_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q <= '0;
    end else if (upd) begin
      rec_q <= rec_d;
    end
  end

  assign rec_o = rec_q;

  AST_REC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !clr_i) |=> $stable(rec_q)); // R11
  AST_REC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (rec_q == '0)); // R7
endmodule

// File: rtl/can_fc_warn.sv
module can_fc_warn #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze_i,
  input  logic [CNT_W-1:0] tec_i,
  input  logic [CNT_W-1:0] rec_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             status_o,
  output logic             irq_o
);
  logic status_q, status_d;
  logic irq_q, irq_d;
  logic over;

  assign over = (tec_i >= limit_i) | (rec_i >= limit_i);

  always_comb begin
    status_d = status_q;
    irq_d    = 1'b0;
    if (!freeze_i) begin
      status_d = over;
      irq_d    = over ^ status_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (!freeze_i) status_q <= status_d;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |=> ($stable(status_q) && !irq_q)); // R9
  AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (status_q != $past(status_q))); // R8
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned TX_INC      = 8,
  parameter int unsigned PASSIVE_TH  = 128,
  parameter int unsigned RECOV_IDLES = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reset_mode_i,
  input  logic [CNT_W-1:0] warn_limit_i,
  input  logic             tx_err_i,
  input  logic             rx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             arb_stuff_err_i,
  input  logic             flag_bit_err_i,
  input  logic             dom_after_flag_i,
  input  logic             bus_idle_i,
  input  logic             transmitter_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic [1:0]       state_o,
  output logic             err_warn_o,
  output logic             err_warn_irq_o,
  output logic             recov_done_o,
  output logic             suspend_tx_o
);
  localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASSIVE_TH);
  localparam logic [CNT_W-1:0] NEAR_V = CNT_W'(PASSIVE_TH - TX_INC);

  logic      bus_off;
  logic      recov_fire;
  logic      rec_freeze;
  logic      warn_freeze;
  fc_state_e state;

  assign rec_freeze  = reset_mode_i | bus_off;
  assign warn_freeze = reset_mode_i | bus_off;

  can_fc_tec #(.CNT_W(CNT_W), .TX_INC(TX_INC), .RECOV_IDLES(RECOV_IDLES)) u_tec (
    .clk          (clk),
    .rst_n        (rst_n),
    .freeze_i     (reset_mode_i),
    .tx_err_i     (tx_err_i),
    .arb_stuff_i  (arb_stuff_err_i),
    .flag_err_i   (flag_bit_err_i),
    .dom_err_i    (dom_after_flag_i),
    .tx_ok_i      (tx_ok_i),
    .idle_i       (bus_idle_i),
    .tec_o        (tec_o),
    .bus_off_o    (bus_off),
    .recov_fire_o (recov_fire),
    .recov_done_o (recov_done_o)
  );

  can_fc_rec #(.CNT_W(CNT_W)) u_rec (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze_i (rec_freeze),
    .clr_i    (recov_fire),
    .rx_err_i (rx_err_i),
    .rx_ok_i  (rx_ok_i),
    .rec_o    (rec_o)
  );

  can_fc_warn #(.CNT_W(CNT_W)) u_warn (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze_i (warn_freeze),
    .tec_i    (tec_o),
    .rec_i    (rec_o),
    .limit_i  (warn_limit_i),
    .status_o (err_warn_o),
    .irq_o    (err_warn_irq_o)
  );

  always_comb begin
    if (bus_off)                                  state = FC_BUSOFF;
    else if (tec_o >= PASS_V || rec_o >= PASS_V)  state = FC_PASSIVE;
    else                                          state = FC_ACTIVE;
  end

  assign state_o      = state;
  assign suspend_tx_o = (state == FC_PASSIVE) & transmitter_i;

  AST_PASSIVE_AT_CROSSING: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_mode_i && !bus_off && tec_o >= NEAR_V && tec_o < PASS_V &&
     tx_err_i && !arb_stuff_err_i) |=> (state_o == FC_PASSIVE)); // R5
  AST_SUSPEND_ONLY_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_tx_o |-> (state_o == FC_PASSIVE)); // R12
  AST_RSTMODE_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode_i |=> $stable(state_o)); // R10
endmodule

// File: tb/can_fault_conf_tb_top.sv
module can_fault_conf_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reset_mode;
  logic [7:0] warn_limit;
  logic       tx_err, rx_err, tx_ok, rx_ok, arb_stuff, flag_err, dom_err, bus_idle;
  logic       transmitter;
  logic [7:0] tec, rec;
  logic [1:0] state;
  logic       warn, warn_irq, recov_done, suspend;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  can_fault_conf dut_i (
    .clk(clk), .rst_n(rst_n), .reset_mode_i(reset_mode), .warn_limit_i(warn_limit),
    .tx_err_i(tx_err), .rx_err_i(rx_err), .tx_ok_i(tx_ok), .rx_ok_i(rx_ok),
    .arb_stuff_err_i(arb_stuff), .flag_bit_err_i(flag_err), .dom_after_flag_i(dom_err),
    .bus_idle_i(bus_idle), .transmitter_i(transmitter),
    .tec_o(tec), .rec_o(rec), .state_o(state), .err_warn_o(warn),
    .err_warn_irq_o(warn_irq), .recov_done_o(recov_done), .suspend_tx_o(suspend)
  );

  // event bits {idle, tx_err, rx_err, tx_ok, rx_ok, arb_stuff, flag_err, dom_err}
  localparam logic [7:0] E_TXE  = 8'b0100_0000;
  localparam logic [7:0] E_RXE  = 8'b0010_0000;
  localparam logic [7:0] E_TXOK = 8'b0001_0000;
  localparam logic [7:0] E_IDLE = 8'b1000_0000;

  // {events[6:0], expected tec, expected rec}, cumulative from reset
  localparam logic [22:0] VEC [9] = '{
    {7'b1000000, 8'd8,  8'd0},   // R2 tx error
    {7'b0100000, 8'd8,  8'd1},   // R3 rx error
    {7'b0010000, 8'd7,  8'd1},   // R2 tx ok
    {7'b0001000, 8'd7,  8'd0},   // R3 rx ok
    {7'b0001000, 8'd7,  8'd0},   // R3 floor at 0
    {7'b1000100, 8'd7,  8'd0},   // R4 stuff error in arbitration
    {7'b0000010, 8'd15, 8'd0},   // R4 flag bit error
    {7'b0000001, 8'd23, 8'd0},   // R4 dominant after flag
    {7'b1100000, 8'd31, 8'd1}    // R2 R3 both
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] ev);
    @(negedge clk);
    {bus_idle, tx_err, rx_err, tx_ok, rx_ok, arb_stuff, flag_err, dom_err} = ev;
    @(negedge clk);
    {bus_idle, tx_err, rx_err, tx_ok, rx_ok, arb_stuff, flag_err, dom_err} = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    reset_mode = 1'b0; warn_limit = 8'd96; transmitter = 1'b0;
    {bus_idle, tx_err, rx_err, tx_ok, rx_ok, arb_stuff, flag_err, dom_err} = '0;
    do_reset();
    chk("R1 tec", tec, 0); chk("R1 rec", rec, 0); chk("R1 state", state, 0);
    chk("R1 warn", warn, 0); chk("R1 irq", warn_irq, 0); chk("R1 done", recov_done, 0);

    for (int i = 0; i < 9; i++) begin
      step({1'b0, VEC[i][22:16]});
      chk("R2/R4 vector tec", tec, VEC[i][15:8]);
      chk("R3 vector rec", rec, VEC[i][7:0]);
    end

    // R8 warning threshold
    warn_limit = 8'd40;
    step(E_TXE); @(negedge clk);
    chk("R8 below limit", warn, 0);
    step(E_TXE); chk("R8 tec", tec, 47);
    @(negedge clk);
    chk("R8 warn set", warn, 1); chk("R8 irq", warn_irq, 1);
    @(negedge clk);
    chk("R8 irq one cycle", warn_irq, 0);
    warn_limit = 8'd96;
    repeat (2) @(negedge clk);
    chk("R8 warn clear", warn, 0);

    // R5 crossing into error-passive
    do_reset();
    for (int i = 0; i < 15; i++) step(E_TXE);
    chk("R5 tec 120", tec, 120); chk("R5 active", state, 0);
    step(E_TXOK); step(E_TXE);
    chk("R5 tec 127", tec, 127); chk("R5 still active", state, 0);
    transmitter = 1'b1; #1;
    chk("R12 active transmitter", suspend, 0);
    step(E_TXE);
    chk("R5 tec 135", tec, 135); chk("R5 passive", state, 1);
    chk("R12 passive transmitter", suspend, 1);
    transmitter = 1'b0; #1;
    chk("R12 lost arbitration", suspend, 0);
    @(negedge clk);
    chk("R8 warn at 135", warn, 1);

    // R10 reset mode freezes everything
    reset_mode = 1'b1;
    step(E_TXE | E_RXE | E_IDLE); @(negedge clk);
    chk("R10 tec", tec, 135); chk("R10 rec", rec, 0);
    chk("R10 state", state, 1); chk("R10 warn", warn, 1);
    reset_mode = 1'b0;

    // R6 into bus-off
    for (int i = 0; i < 3; i++) step(E_RXE);
    chk("R3 rec 3", rec, 3);
    for (int i = 0; i < 15; i++) step(E_TXE);
    chk("R6 tec 255", tec, 255); chk("R6 passive", state, 1);
    step(E_TXE);
    chk("R6 busoff", state, 2); chk("R6 tec loaded", tec, 128);
    step(E_RXE);
    chk("R11 rec frozen", rec, 3);
    step(E_TXE);
    chk("R7 tx ignored", tec, 128);

    // R7 recovery with a reset-mode pause
    for (int i = 0; i < 60; i++) begin
      step(E_IDLE);
      chk("R9 no irq", warn_irq, 0);
    end
    chk("R7 tec 68", tec, 68);
    reset_mode = 1'b1;
    step(E_IDLE);
    chk("R10 idle ignored", tec, 68);
    reset_mode = 1'b0;
    for (int i = 0; i < 67; i++) begin
      step(E_IDLE);
      chk("R9 no irq", warn_irq, 0);
      chk("R9 warn held", warn, 1);
    end
    chk("R7 tec 1", tec, 1); chk("R7 still busoff", state, 2);
    chk("R7 no done", recov_done, 0);
    step(E_IDLE);
    chk("R7 done", recov_done, 1); chk("R7 tec 0", tec, 0);
    chk("R7 rec 0", rec, 0); chk("R7 active", state, 0);
    @(negedge clk);
    chk("R7 done one cycle", recov_done, 0);
    chk("R8 warn drop", warn, 0); chk("R8 irq on drop", warn_irq, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule